// File: doc/BRIEF.md
# Branch History Table Predictor

A small direct-mapped table that guesses the direction and destination of conditional branches while they are being fetched. Every entry pairs a branch address tag with a two-bit history state and the branch's destination address. The lookup side is purely combinational. It takes the fetch PC and returns three things: a hit flag, a taken guess and the next fetch address. On a hit that predicts taken, the next fetch address is the stored destination, so fetch can be redirected before the branch is decoded. In every other case it is the sequential address.

Once a branch resolves, the update side receives its PC, the actual direction and the actual destination. It then refreshes the matching entry, or claims one for a taken branch that was not in the table. The history can behave as a two-bit hysteresis counter, or it can follow the last outcome only, as chosen by a mode input.

Top module: `bht_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup miss reports hit 0 and taken 0, and the next fetch address is the lookup PC plus 4.
- R3: The entry index is PC[5:2] and the tag is PC[31:6]. PC[1:0] plays no part in matching. A PC with the same index but a different tag misses.
- R4: An update with taken 1 that misses writes the entry: valid, with the tag, state 2'b10 (weak taken) and the given destination. A lookup at that PC then hits, predicts taken and returns that destination.
- R5: An update with taken 0 that misses leaves the table unchanged. A later lookup at that PC still misses.
- R6: The history states are encoded 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken, and the prediction is bit 1 of the state. In two-bit mode (single_bit_i = 0), a correct outcome moves the state one step toward the strong state of its direction. From a strong state, one wrong outcome does not change the prediction.
- R7: In two-bit mode, a wrong outcome from a weak state jumps to the strong opposite state. So 10 followed by not-taken gives 00, and 01 followed by taken gives 11.
- R8: In single-bit mode (single_bit_i = 1), an update on a hit sets the state to 11 if the branch was taken and to 00 if not. The next prediction therefore equals the last outcome.
- R9: A taken update on a hit replaces the stored destination. A not-taken update on a hit keeps the stored destination.
- R10: When a lookup and an update address the same entry in the same cycle, the lookup returns the contents from before the update. The new contents are visible from the next cycle.
- R11: A taken update that misses on an index holding a different tag replaces that entry. The old branch then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| single_bit_i | input | 1 | 1: history follows the last outcome only; 0: two-bit hysteresis |
| lk_pc_i | input | 32 | Fetch PC to look up |
| lk_hit_o | output | 1 | Valid entry with matching tag |
| lk_taken_o | output | 1 | Predicted taken |
| lk_target_o | output | 32 | Next fetch address |
| upd_valid_i | input | 1 | Resolved branch present this cycle |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual direction |
| upd_target_i | input | 32 | Actual destination |

## Verification
The bench walks one entry through the whole hysteresis ring. It checks that a single wrong outcome from strong taken keeps the guess. It also checks that a weak state jumps straight to the strong opposite, which a plain saturating counter would get wrong by stopping in the adjacent weak state. The bench probes tag aliasing on a shared index and confirms that the low PC bits are ignored. It also checks that a not-taken miss does not allocate: a wrong design would create a taken entry for a branch never seen taken. A same-cycle lookup and update on one entry must show the old prediction, so forwarding the write would show up as an early flip. Single-bit mode must flip after one wrong outcome, and destination refresh must happen only on taken outcomes.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef enum logic [1:0] {
    ST_SNT = 2'b00,
    ST_WNT = 2'b01,
    ST_WT  = 2'b10,
    ST_ST  = 2'b11
  } bht_state_e;

  localparam bht_state_e ALLOC_STATE = ST_WT;
endpackage

// File: rtl/bht_ctr_next.sv
module bht_ctr_next
  import bht_pkg::*;
(
  input  bht_state_e cur_i,
  input  logic       taken_i,
  input  logic       single_bit_i,
  output bht_state_e nxt_o
);
  always_comb begin
    if (single_bit_i) begin
      nxt_o = taken_i ? ST_ST : ST_SNT;
    end else begin
      unique case (cur_i)
        ST_SNT:  nxt_o = taken_i ? ST_WNT : ST_SNT;
        ST_WNT:  nxt_o = taken_i ? ST_ST  : ST_SNT;  // wrong from weak: jump
        ST_WT:   nxt_o = taken_i ? ST_ST  : ST_SNT;  // wrong from weak: jump
        default: nxt_o = taken_i ? ST_ST  : ST_WT;
      endcase
    end
  end
endmodule

// File: rtl/bht_store.sv
module bht_store
  import bht_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output bht_state_e        rd_state_o,
  output logic [PC_W-1:0]   rd_target_o,
  input  logic [IDX_W-1:0]  up_idx_i,
  output logic              up_valid_o,
  output logic [TAG_W-1:0]  up_tag_o,
  output bht_state_e        up_state_o,
  output logic [PC_W-1:0]   up_target_o,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  bht_state_e        wr_state_i,
  input  logic [PC_W-1:0]   wr_target_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]            valid_q;
  logic [TAG_W-1:0]            tag_q    [DEPTH];
  bht_state_e                  state_q  [DEPTH];
  logic [PC_W-1:0]             target_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g]  <= 1'b0;
        tag_q[g]    <= '0;
        state_q[g]  <= ST_SNT;
        target_q[g] <= '0;
      end else if (wr_en_i && up_idx_i == IDX_W'(g)) begin
        valid_q[g]  <= 1'b1;
        tag_q[g]    <= wr_tag_i;
        state_q[g]  <= wr_state_i;
        target_q[g] <= wr_target_i;
      end
    end
  end

  // reads see pre-write contents
  assign rd_valid_o  = valid_q[rd_idx_i];
  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_state_o  = state_q[rd_idx_i];
  assign rd_target_o = target_q[rd_idx_i];
  assign up_valid_o  = valid_q[up_idx_i];
  assign up_tag_o    = tag_q[up_idx_i];
  assign up_state_o  = state_q[up_idx_i];
  assign up_target_o = target_q[up_idx_i];
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            single_bit_i,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_hit_o,
  output logic            lk_taken_o,
  output logic [PC_W-1:0] lk_target_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i
);
  localparam int LSB   = 2;
  localparam int TAG_W = PC_W - IDX_W - LSB;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             unused_pc_lsb;

  assign lk_idx = lk_pc_i[LSB +: IDX_W];
  assign up_idx = upd_pc_i[LSB +: IDX_W];
  assign lk_tag = lk_pc_i[PC_W-1 -: TAG_W];
  assign up_tag = upd_pc_i[PC_W-1 -: TAG_W];
  assign unused_pc_lsb = ^{lk_pc_i[LSB-1:0], upd_pc_i[LSB-1:0]};

  logic             rd_valid, ue_valid;
  logic [TAG_W-1:0] rd_tag, ue_tag;
  bht_state_e       rd_state, ue_state;
  logic [PC_W-1:0]  rd_target, ue_target;

  logic             wr_en;
  bht_state_e       wr_state, nxt_state;
  logic [PC_W-1:0]  wr_target;
  logic             upd_hit;

  bht_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (lk_idx),
    .rd_valid_o  (rd_valid),
    .rd_tag_o    (rd_tag),
    .rd_state_o  (rd_state),
    .rd_target_o (rd_target),
    .up_idx_i    (up_idx),
    .up_valid_o  (ue_valid),
    .up_tag_o    (ue_tag),
    .up_state_o  (ue_state),
    .up_target_o (ue_target),
    .wr_en_i     (wr_en),
    .wr_tag_i    (up_tag),
    .wr_state_i  (wr_state),
    .wr_target_i (wr_target)
  );

  bht_ctr_next u_next (
    .cur_i        (ue_state),
    .taken_i      (upd_taken_i),
    .single_bit_i (single_bit_i),
    .nxt_o        (nxt_state)
  );

  // lookup
  always_comb begin
    lk_hit_o    = rd_valid && (rd_tag == lk_tag);
    lk_taken_o  = lk_hit_o && rd_state[1];
    lk_target_o = lk_taken_o ? rd_target : lk_pc_i + PC_W'(4);
  end

  // update / allocate
  always_comb begin
    upd_hit   = ue_valid && (ue_tag == up_tag);
    wr_en     = upd_valid_i && (upd_hit || upd_taken_i);
    wr_state  = upd_hit ? nxt_state : ALLOC_STATE;
    wr_target = upd_taken_i ? upd_target_i : ue_target;
  end
endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            single_bit_i,
  input logic [PC_W-1:0] lk_pc_i,
  input logic            lk_hit_o,
  input logic            lk_taken_o,
  input logic [PC_W-1:0] lk_target_o,
  input logic            upd_valid_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic            upd_taken_i,
  input logic [PC_W-1:0] upd_target_i
);
  // R2: a miss falls through to the sequential address
  a_r2_miss_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (!lk_taken_o && lk_target_o == lk_pc_i + PC_W'(4)));

  // R5: a not-taken update that misses never creates an entry
  a_r5_no_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && lk_pc_i == upd_pc_i && !lk_hit_o)
    |=> ((lk_pc_i == $past(lk_pc_i)) -> !lk_hit_o));

  // R8: single-bit mode follows the last outcome, R9: taken refreshes destination
  a_r8_single_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && single_bit_i && lk_pc_i == upd_pc_i && lk_hit_o)
    |=> ((lk_pc_i == $past(lk_pc_i)) -> (lk_hit_o && lk_taken_o == $past(upd_taken_i))));

  a_r9_target_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && single_bit_i)
    |=> ((lk_pc_i == $past(upd_pc_i) && single_bit_i)
         -> (lk_hit_o && lk_taken_o && lk_target_o == $past(upd_target_i))));

  // R10: without an update the prediction for a held PC stays put
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> ($stable(lk_pc_i) -> ($stable(lk_hit_o) && $stable(lk_taken_o)
                                           && $stable(lk_target_o))));
endmodule

bind bht_predictor bht_predictor_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/bht_predictor_tb.sv
module bht_predictor_tb;
  localparam int PC_W = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            single_bit_i = 1'b0;
  logic [PC_W-1:0] lk_pc_i = '0;
  logic            lk_hit_o, lk_taken_o;
  logic [PC_W-1:0] lk_target_o;
  logic            upd_valid_i = 1'b0;
  logic [PC_W-1:0] upd_pc_i = '0;
  logic            upd_taken_i = 1'b0;
  logic [PC_W-1:0] upd_target_i = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bht_predictor u_dut (.*);

  localparam logic [31:0] PC_A = 32'h0000_1010; // idx 4
  localparam logic [31:0] PC_C = 32'h0000_2010; // idx 4, other tag
  localparam logic [31:0] PC_B = 32'h0000_3020; // idx 8
  localparam logic [31:0] PC_D = 32'h0000_4030; // idx 12
  localparam logic [31:0] T1   = 32'h0000_8000;
  localparam logic [31:0] T2   = 32'h0000_9000;
  localparam logic [31:0] T3   = 32'h0000_A000;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(logic [31:0] pc, bit hit, bit tk, logic [31:0] tgt, string req);
    lk_pc_i = pc;
    #0.5;
    check({req, " hit"}, 32'(lk_hit_o), 32'(hit));
    check({req, " taken"}, 32'(lk_taken_o), 32'(tk));
    check({req, " target"}, lk_target_o, tgt);
  endtask

  task automatic upd(logic [31:0] pc, bit tk, logic [31:0] tgt);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = tk; upd_target_i = tgt;
    @(posedge clk_i);
    #0.5;
    upd_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    look(PC_A, 0, 0, PC_A + 4, "R1");
    look(PC_B, 0, 0, PC_B + 4, "R2");
  endtask

  task automatic t_alloc_and_ring();
    upd(PC_A, 1, T1);
    look(PC_A, 1, 1, T1, "R4");
    upd(PC_A, 1, T1);             // 10 -> 11
    upd(PC_A, 0, T2);             // 11 -> 10, still taken
    look(PC_A, 1, 1, T1, "R6 strong keeps");
    upd(PC_A, 0, T2);             // 10 -> 00
    look(PC_A, 1, 0, PC_A + 4, "R7 weak to strong nt");
    upd(PC_A, 1, T2);             // 00 -> 01
    look(PC_A, 1, 0, PC_A + 4, "R6 one wrong from strong nt");
    upd(PC_A, 1, T2);             // 01 -> 11
    look(PC_A, 1, 1, T2, "R7 weak nt to strong t");
    upd(PC_A, 0, T3);             // 11 -> 10, target kept
    look(PC_A, 1, 1, T2, "R9 nt keeps target");
  endtask

  task automatic t_no_alloc();
    upd(PC_B, 0, T3);
    look(PC_B, 0, 0, PC_B + 4, "R5");
  endtask

  task automatic t_tags();
    look(PC_C, 0, 0, PC_C + 4, "R3 alias miss");
    look(PC_A | 32'h3, 1, 1, T2, "R3 low bits ignored");
    upd(PC_C, 1, T3);
    look(PC_C, 1, 1, T3, "R11 new owner");
    look(PC_A, 0, 0, PC_A + 4, "R11 evicted");
  endtask

  task automatic t_single();
    single_bit_i = 1'b1;
    upd(PC_D, 1, T1);
    look(PC_D, 1, 1, T1, "R8 alloc");
    upd(PC_D, 0, T1);
    look(PC_D, 1, 0, PC_D + 4, "R8 one nt flips");
    upd(PC_D, 1, T2);
    look(PC_D, 1, 1, T2, "R8 one t flips");
  endtask

  task automatic t_same_cycle();
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_pc_i = PC_D; upd_taken_i = 1'b0; upd_target_i = T3;
    lk_pc_i = PC_D;
    #0.5;
    check("R10 old hit", 32'(lk_hit_o), 32'd1);
    check("R10 old taken", 32'(lk_taken_o), 32'd1);
    check("R10 old target", lk_target_o, T2);
    @(posedge clk_i);
    #0.5;
    upd_valid_i = 1'b0;
    look(PC_D, 1, 0, PC_D + 4, "R10 new visible");
    single_bit_i = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #0.5;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_alloc_and_ring();
    t_no_alloc();
    t_tags();
    t_single();
    t_same_cycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule